// File: doc/BRIEF.md
# Reassembly Cell Port Router

Every received cell reaches this block after its connection entry has been looked up. The block reads a few fields of that entry and picks one of three fates for the cell. A cell on an interworking channel goes to one of several per-port host FIFOs if that FIFO has room. An interworking cell that cannot be delivered is dropped. Every other cell continues down the ordinary reassembly path.

A cell is treated as an interworking cell only when three things are true: the interworking enable bit of entry word 0 is set, the channel is in logical-FIFO mode (one-cell termination), and the 52-octet cell mode is on. For such a cell, the entry's priority field names the destination port. A forwarded cell carries a rewritten header word. Its upper bits hold a routing tag, taken from the top of the entry's buffer-descriptor pointer word. Its low bits keep the payload-type and cell-loss-priority bits of the original header.

The decision is registered. It appears as a single-cycle strobe in the clock after the cell-valid input.

Top module: `cell_port_router`

## Requirements
- R1: While synchronous reset `rst` is high, and in the cycle after it, `fwd_vld`, `drop_vld` and `norm_vld` are 0, and `fwd_port` and `fwd_hdr` are 0.
- R2: For every clock in which `cell_vld` is 1, exactly one of `fwd_vld`, `drop_vld`, `norm_vld` is 1 in the next clock. After a clock with `cell_vld` 0, all three are 0.
- R3: If bit 21 of `ent_word0` is 0, the cell takes the normal path (`norm_vld`).
- R4: If `ent_fifo_mode` is 0, the cell takes the normal path.
- R5: If `ent_cell52` is 0, the cell takes the normal path.
- R6: An interworking cell whose `ent_prio` is below 6 and whose `port_room[ent_prio]` is 1 is forwarded: `fwd_vld` is 1 and `fwd_port` equals `ent_prio`.
- R7: An interworking cell whose `ent_prio` is below 6 and whose `port_room[ent_prio]` is 0 is discarded (`drop_vld`).
- R8: An interworking cell whose `ent_prio` is 6 or 7 is discarded, whatever `port_room` holds.
- R9: On a forward, `fwd_hdr` equals {`ent_bd_word[31:4]`, `hdr_in[3:0]`}. This is the 28-bit routing tag followed by PTI[2:0] and CLP.
- R10: `fwd_port` and `fwd_hdr` change only on a forward. After a discard, a normal-path cell or an idle clock they keep the values of the last forward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cell_vld | input | 1 | One looked-up cell is presented this clock |
| ent_word0 | input | 32 | Connection entry word 0; bit 21 is the interworking enable |
| ent_prio | input | 3 | Entry priority field, used as the destination port |
| ent_bd_word | input | 32 | Buffer-descriptor pointer word; upper 28 bits are the routing tag |
| ent_fifo_mode | input | 1 | Channel is in logical-FIFO (one-cell termination) mode |
| ent_cell52 | input | 1 | 52-octet cell mode enable |
| hdr_in | input | 32 | Original cell header word |
| port_room | input | 6 | Per-port room-available flags |
| fwd_vld | output | 1 | Cell forwarded to a port FIFO |
| fwd_port | output | 3 | Selected destination port |
| fwd_hdr | output | 32 | Rewritten header word |
| drop_vld | output | 1 | Interworking cell discarded |
| norm_vld | output | 1 | Cell continues on the normal reassembly path |

## Verification
On every cycle, the assertions check the one-hot, one-cycle-late strobe protocol. They also check the quiet outputs around reset, that a forward never names a port outside the six, and that each mode bit, the room flag and an invalid port steer the cell to the right strobe. The header rewrite and the holding of the port and header between forwards are shown only by the bench. The bench compares them against its own model, using random entries together with directed cases for ports 6 and 7, full FIFOs and each missing enable bit.

// File: rtl/cell_port_router.sv
module cell_port_router #(
  parameter int W       = 32,
  parameter int TAG_W   = 28,
  parameter int NPORT   = 6,
  parameter int PRIO_W  = 3,
  parameter int IW_BIT  = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cell_vld,
  input  logic [W-1:0]      ent_word0,
  input  logic [PRIO_W-1:0] ent_prio,
  input  logic [W-1:0]      ent_bd_word,
  input  logic              ent_fifo_mode,
  input  logic              ent_cell52,
  input  logic [W-1:0]      hdr_in,
  input  logic [NPORT-1:0]  port_room,
  output logic              fwd_vld,
  output logic [PRIO_W-1:0] fwd_port,
  output logic [W-1:0]      fwd_hdr,
  output logic              drop_vld,
  output logic              norm_vld
);
  localparam int LOW_W = W - TAG_W;

  logic iw_cell, port_ok, room_hit, go_fwd, go_drop, go_norm;

  assign iw_cell = ent_word0[IW_BIT] & ent_fifo_mode & ent_cell52;
  assign port_ok = ent_prio < PRIO_W'(NPORT);

  always_comb begin
    room_hit = 1'b0;
    for (int i = 0; i < NPORT; i++)
      if (ent_prio == PRIO_W'(i)) room_hit = port_room[i];
  end

  assign go_norm = cell_vld & ~iw_cell;
  assign go_fwd  = cell_vld & iw_cell & port_ok & room_hit;
  assign go_drop = cell_vld & iw_cell & ~(port_ok & room_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_vld  <= 1'b0;
      drop_vld <= 1'b0;
      norm_vld <= 1'b0;
      fwd_port <= '0;
      fwd_hdr  <= '0;
    end else begin
      fwd_vld  <= go_fwd;
      drop_vld <= go_drop;
      norm_vld <= go_norm;
      if (go_fwd) begin
        fwd_port <= ent_prio;
        fwd_hdr  <= {ent_bd_word[W-1 -: TAG_W], hdr_in[LOW_W-1:0]};
      end
    end
  end
endmodule

module cell_port_router_chk #(
  parameter int W       = 32,
  parameter int NPORT   = 6,
  parameter int PRIO_W  = 3,
  parameter int IW_BIT  = 21
) (
  input logic              clk,
  input logic              rst,
  input logic              cell_vld,
  input logic [W-1:0]      ent_word0,
  input logic [PRIO_W-1:0] ent_prio,
  input logic              ent_fifo_mode,
  input logic              ent_cell52,
  input logic [NPORT-1:0]  port_room,
  input logic              fwd_vld,
  input logic [PRIO_W-1:0] fwd_port,
  input logic              drop_vld,
  input logic              norm_vld
);
  logic [2**PRIO_W-1:0] room_wide;
  assign room_wide = (2**PRIO_W)'(port_room);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> !fwd_vld && !drop_vld && !norm_vld);
  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    cell_vld |=> $countones({fwd_vld, drop_vld, norm_vld}) == 1);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !cell_vld |=> !fwd_vld && !drop_vld && !norm_vld);
  assert_no_enable_R3: assert property (@(posedge clk) disable iff (rst)
    (cell_vld && !ent_word0[IW_BIT]) |=> norm_vld);
  assert_no_fifo_mode_R4: assert property (@(posedge clk) disable iff (rst)
    (cell_vld && !ent_fifo_mode) |=> norm_vld);
  assert_no_cell52_R5: assert property (@(posedge clk) disable iff (rst)
    (cell_vld && !ent_cell52) |=> norm_vld);
  assert_fwd_port_range_R6: assert property (@(posedge clk) disable iff (rst)
    fwd_vld |-> fwd_port < PRIO_W'(NPORT));
  assert_full_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (cell_vld && ent_word0[IW_BIT] && ent_fifo_mode && ent_cell52 &&
     !room_wide[ent_prio]) |=> drop_vld);
  assert_bad_port_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (cell_vld && ent_word0[IW_BIT] && ent_fifo_mode && ent_cell52 &&
     ent_prio >= PRIO_W'(NPORT)) |=> drop_vld);
endmodule

bind cell_port_router cell_port_router_chk #(
  .W(W), .NPORT(NPORT), .PRIO_W(PRIO_W), .IW_BIT(IW_BIT)
) u_chk (.*);

// File: tb/sim_cell_port_router.sv
module sim_cell_port_router;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cell_vld = 1'b0;
  logic [31:0] ent_word0 = '0;
  logic [2:0]  ent_prio = '0;
  logic [31:0] ent_bd_word = '0;
  logic        ent_fifo_mode = 1'b0;
  logic        ent_cell52 = 1'b0;
  logic [31:0] hdr_in = '0;
  logic [5:0]  port_room = '0;
  logic        fwd_vld, drop_vld, norm_vld;
  logic [2:0]  fwd_port;
  logic [31:0] fwd_hdr;

  int checks = 0;
  int fails  = 0;
  logic [2:0]  exp_port = '0;
  logic [31:0] exp_hdr  = '0;

  always #5 clk = ~clk;

  cell_port_router u0 (
    .clk(clk), .rst(rst), .cell_vld(cell_vld), .ent_word0(ent_word0),
    .ent_prio(ent_prio), .ent_bd_word(ent_bd_word), .ent_fifo_mode(ent_fifo_mode),
    .ent_cell52(ent_cell52), .hdr_in(hdr_in), .port_room(port_room),
    .fwd_vld(fwd_vld), .fwd_port(fwd_port), .fwd_hdr(fwd_hdr),
    .drop_vld(drop_vld), .norm_vld(norm_vld)
  );

  // result encoding: 0 idle, 1 forward, 2 drop, 3 normal
  function automatic int fate(logic v, logic [31:0] w0, logic fm, logic c52,
                              logic [2:0] p, logic [5:0] room);
    if (!v) return 0;
    if (!(w0[21] && fm && c52)) return 3;
    if (p >= 3'd6) return 2;
    return room[p] ? 1 : 2;
  endfunction

  function automatic logic [31:0] new_hdr(logic [31:0] bd, logic [31:0] h);
    return {bd[31:4], h[3:0]};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_cell(string req, logic v, logic [31:0] w0, logic fm,
                          logic c52, logic [2:0] p, logic [5:0] room,
                          logic [31:0] bd, logic [31:0] h);
    int f;
    cell_vld = v; ent_word0 = w0; ent_fifo_mode = fm; ent_cell52 = c52;
    ent_prio = p; port_room = room; ent_bd_word = bd; hdr_in = h;
    f = fate(v, w0, fm, c52, p, room);
    if (f == 1) begin exp_port = p; exp_hdr = new_hdr(bd, h); end
    @(negedge clk);
    chk({req, " strobes"}, {61'd0, fwd_vld, drop_vld, norm_vld},
        {61'd0, f == 1, f == 2, f == 3});
    chk("R6/R10 port", {61'd0, fwd_port}, {61'd0, exp_port});
    chk("R9/R10 hdr", {32'd0, fwd_hdr}, {32'd0, exp_hdr});
    cell_vld = 1'b0;
  endtask

  localparam logic [31:0] IW = 32'h0020_0000;

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 reset strobes", {61'd0, fwd_vld, drop_vld, norm_vld}, 64'd0);
    chk("R1 reset port", {61'd0, fwd_port}, 64'd0);
    chk("R1 reset hdr", {32'd0, fwd_hdr}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", {61'd0, fwd_vld, drop_vld, norm_vld}, 64'd0);

    run_cell("R3", 1, 32'hFFDF_FFFF, 1, 1, 3'd2, 6'h3F, 32'hAAAA_AAA0, 32'h1234_5675);
    run_cell("R4", 1, IW, 0, 1, 3'd2, 6'h3F, 32'h1, 32'h2);
    run_cell("R5", 1, IW, 1, 0, 3'd2, 6'h3F, 32'h1, 32'h2);
    run_cell("R6", 1, IW, 1, 1, 3'd0, 6'h01, 32'hDEAD_BEE0, 32'h0000_000B);
    run_cell("R9", 1, IW, 1, 1, 3'd5, 6'h20, 32'h1234_567F, 32'hFFFF_FFF4);
    run_cell("R7", 1, IW, 1, 1, 3'd3, 6'h37, 32'h5, 32'h6);
    run_cell("R8", 1, IW, 1, 1, 3'd6, 6'h3F, 32'h7, 32'h8);
    run_cell("R8", 1, IW, 1, 1, 3'd7, 6'h3F, 32'h7, 32'h8);
    run_cell("R2 idle", 0, IW, 1, 1, 3'd1, 6'h3F, 32'h9, 32'hA);
    run_cell("R10", 1, 32'h0, 1, 1, 3'd1, 6'h3F, 32'hB, 32'hC);

    for (int n = 0; n < 400; n++) begin
      logic [31:0] w0;
      w0 = $urandom();
      if ($urandom_range(0, 3) != 0) w0[21] = 1'b1;
      run_cell("R2 random", $urandom_range(0, 5) != 0, w0,
               $urandom_range(0, 4) != 0, $urandom_range(0, 4) != 0,
               3'($urandom_range(0, 7)), 6'($urandom()), $urandom(), $urandom());
    end

    // back-to-back with reset mid-stream
    run_cell("R6", 1, IW, 1, 1, 3'd4, 6'h10, 32'hCAFE_0000, 32'h3);
    rst = 1'b1;
    exp_port = '0; exp_hdr = '0;
    @(negedge clk);
    chk("R1 mid reset", {29'd0, fwd_port, fwd_vld, drop_vld, norm_vld}, 64'd0);
    chk("R1 mid reset hdr", {32'd0, fwd_hdr}, 64'd0);
    rst = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule